// File: doc/BRIEF.md
# Dual converter trigger dispatcher

This block sits between the conversion trigger sources and a pair of converter cores. Two one-cycle trigger strobes are merged into a single request: a hardware start event and a software start. A 2-bit mode field then decides where the request goes. It can go to both cores at once, or alternately to core 0 and core 1. When the second core is not enabled as a client, every request goes to core 0 only. The block sends each core a one-cycle start pulse and shows which core an alternating request will use next.

The block tracks whether each core is busy, from its own start pulse until that core returns a one-cycle completion strobe. When a request targets a busy core, that start is dropped and a sticky overrun flag is raised. In free-run mode, a completion restarts conversion without any new trigger. In the fan-out and core-0-only arrangements the finishing core restarts itself. In the alternating arrangement the finishing core starts the other core.

Top module: `dtd_dispatch`

## Requirements
- R1: During and after reset, both start pulses are low, `next_core` is 0, `overrun` is 0 and both cores count as idle.
- R2: A start is a one-cycle pulse in the cycle after the request. A hardware event and a software start in the same cycle count as a single trigger, so the alternating pointer advances once.
- R3: With `client_en`=1 and `trig_mode`=0, a trigger starts both idle cores in the same cycle.
- R4: With `client_en`=1 and `trig_mode`=1, triggers alternate between the cores, starting with core 0. `next_core` shows the core the next trigger will use (0 = core 0, 1 = core 1).
- R5: Any change of the effective mode returns the alternating pointer to core 0.
- R6: With `client_en`=0, any trigger starts core 0 only, whatever the value of `trig_mode`, and `conv_start[1]` stays low.
- R7: With `client_en`=1 and `trig_mode` set to 2 or 3, triggers and completions start nothing and leave `overrun` unchanged.
- R8: A request to a core that has started and has not yet signalled completion is dropped and sets `overrun`. `overrun` then stays set until reset. After the core's completion, the core can be started again.
- R9: With `free_run`=1 in fan-out or core-0-only operation, a completion on core k starts core k again in the next cycle.
- R10: With `free_run`=1 in alternating operation, a completion on core 0 starts core 1 and `next_core` becomes 0. A completion on core 1 starts core 0 and `next_core` becomes 1.
- R11: With `free_run`=0, a completion starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Hardware start event strobe |
| sw_start | input | 1 | Software start strobe |
| trig_mode | input | 2 | 0 = fan-out to both cores, 1 = alternate, 2..3 reserved |
| client_en | input | 1 | Second core enabled as a client |
| free_run | input | 1 | Restart automatically on completion |
| conv_done | input | 2 | Per-core conversion-complete strobe (bit k = core k) |
| conv_start | output | 2 | Per-core registered start pulse (bit k = core k) |
| next_core | output | 1 | Core targeted by the next alternating trigger |
| overrun | output | 1 | Sticky flag: a start request hit a busy core |

## Verification
The bound checker checks these rules on every cycle:
- every start pulse follows a trigger or a completion;
- core 1 stays quiet while the client is disabled;
- reserved modes start nothing;
- with free run off, alternating triggers never start both cores at once;
- once `overrun` is set, it stays set;
- the pointer toggles on each alternating trigger.

Some behaviour depends on the history of busy cores and on exact cycle counts, and only the directed scenarios can show it:
- which core each trigger actually reaches;
- a dropped start while a core is busy;
- the pointer returning to core 0 after a mode change;
- the self-restart in free-run mode versus the cross-restart between cores.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  // Effective routing arrangement after client enable and mode decoding
  typedef enum logic [1:0] {
    EM_SINGLE = 2'd0,  // client disabled: core 0 only
    EM_BOTH   = 2'd1,  // fan out to both cores
    EM_ALT    = 2'd2,  // alternate between cores
    EM_IDLE   = 2'd3   // reserved mode code: nothing started
  } eff_mode_t;

  localparam int unsigned NUM_CORES = 2;
  localparam logic [1:0]  CODE_BOTH = 2'd0;
  localparam logic [1:0]  CODE_ALT  = 2'd1;
endpackage

// File: rtl/dtd_trig_merge.sv
module dtd_trig_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] src,
  output logic             trig
);
  // Coincident strobes collapse into one trigger
  assign trig = |src;
endmodule

// File: rtl/dtd_route.sv
module dtd_route
  import dtd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  eff_mode_t            mode_eff,
  input  logic                 trig,
  input  logic                 free_run,
  input  logic [NUM_CORES-1:0] done,
  output logic [NUM_CORES-1:0] req,
  output logic                 ptr_q
);
  eff_mode_t mode_prev_q;
  logic      ptr_eff;
  logic      ptr_d;

  always_comb begin
    ptr_eff = (mode_eff != mode_prev_q) ? 1'b0 : ptr_q;
    ptr_d   = ptr_eff;
    req     = '0;
    case (mode_eff)
      EM_SINGLE: begin
        req[0] = trig | (free_run & done[0]);
      end
      EM_BOTH: begin
        req[0] = trig | (free_run & done[0]);
        req[1] = trig | (free_run & done[1]);
      end
      EM_ALT: begin
        if (trig) req[ptr_eff] = 1'b1;
        if (free_run & done[0]) req[1] = 1'b1;
        if (free_run & done[1]) req[0] = 1'b1;
        if (trig)                    ptr_d = ~ptr_eff;
        else if (free_run & done[1]) ptr_d = 1'b1;
        else if (free_run & done[0]) ptr_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= 1'b0;
      mode_prev_q <= EM_SINGLE;
    end else begin
      ptr_q       <= ptr_d;
      mode_prev_q <= mode_eff;
    end
  end
endmodule

// File: rtl/dtd_core_track.sv
module dtd_core_track #(
  parameter int unsigned NCORE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCORE-1:0] req,
  input  logic [NCORE-1:0] done,
  output logic [NCORE-1:0] start_q,
  output logic             ovr_hit
);
  logic [NCORE-1:0] busy_q;
  logic [NCORE-1:0] hit;

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    logic free_k;
    logic go_k;
    // A completion in this cycle frees the core for an immediate restart
    assign free_k = ~busy_q[k] | done[k];
    assign go_k   = req[k] & free_k;
    assign hit[k] = req[k] & ~free_k;

    always_ff @(posedge clk) begin
      if (rst) begin
        start_q[k] <= 1'b0;
        busy_q[k]  <= 1'b0;
      end else begin
        start_q[k] <= go_k;
        if (go_k)         busy_q[k] <= 1'b1;
        else if (done[k]) busy_q[k] <= 1'b0;
      end
    end
  end

  assign ovr_hit = |hit;
endmodule

// File: rtl/dtd_dispatch.sv
module dtd_dispatch
  import dtd_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_start,
  input  logic                 sw_start,
  input  logic [MODE_W-1:0]    trig_mode,
  input  logic                 client_en,
  input  logic                 free_run,
  input  logic [NUM_CORES-1:0] conv_done,
  output logic [NUM_CORES-1:0] conv_start,
  output logic                 next_core,
  output logic                 overrun
);
  localparam int unsigned N_SRC = 2;

  eff_mode_t            mode_eff;
  logic                 trig;
  logic [NUM_CORES-1:0] req;
  logic                 ovr_hit;
  logic                 overrun_q;

  always_comb begin
    if (!client_en)                     mode_eff = EM_SINGLE;
    else if (trig_mode == MODE_W'(CODE_BOTH)) mode_eff = EM_BOTH;
    else if (trig_mode == MODE_W'(CODE_ALT))  mode_eff = EM_ALT;
    else                                mode_eff = EM_IDLE;
  end

  dtd_trig_merge #(.N_SRC(N_SRC)) u_merge (
    .src  ({sw_start, evt_start}),
    .trig (trig)
  );

  dtd_route u_route (
    .clk      (clk),
    .rst      (rst),
    .mode_eff (mode_eff),
    .trig     (trig),
    .free_run (free_run),
    .done     (conv_done),
    .req      (req),
    .ptr_q    (next_core)
  );

  dtd_core_track #(.NCORE(NUM_CORES)) u_track (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .done    (conv_done),
    .start_q (conv_start),
    .ovr_hit (ovr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun_q <= 1'b0;
    else     overrun_q <= overrun_q | ovr_hit;
  end

  assign overrun = overrun_q;
endmodule

// File: rtl/dtd_dispatch_chk.sv
module dtd_dispatch_chk (
  input logic       clk,
  input logic       rst,
  input logic       evt_start,
  input logic       sw_start,
  input logic [1:0] trig_mode,
  input logic       client_en,
  input logic       free_run,
  input logic [1:0] conv_done,
  input logic [1:0] conv_start,
  input logic       next_core,
  input logic       overrun
);
  // R2: a start only follows a trigger or a completion
  a_r2_start_has_cause: assert property (@(posedge clk) disable iff (rst)
    (|conv_start) |-> $past(evt_start | sw_start | (|conv_done)));

  a_r6_client_off_core1_quiet: assert property (@(posedge clk) disable iff (rst)
    !client_en |=> !conv_start[1]);

  a_r7_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (client_en && trig_mode[1]) |=> (conv_start == 2'b00));

  a_r4_alt_one_core: assert property (@(posedge clk) disable iff (rst)
    (client_en && trig_mode == 2'd1 && !free_run) |=> !(conv_start[0] && conv_start[1]));

  a_r4_pointer_toggles: assert property (@(posedge clk) disable iff (rst)
    (client_en && trig_mode == 2'd1 && $past(client_en && trig_mode == 2'd1)
     && (evt_start | sw_start)) |=> (next_core != $past(next_core)));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r11_no_self_start: assert property (@(posedge clk) disable iff (rst)
    (!free_run && !evt_start && !sw_start) |=> (conv_start == 2'b00));
endmodule

bind dtd_dispatch dtd_dispatch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_start  (evt_start),
  .sw_start   (sw_start),
  .trig_mode  (trig_mode),
  .client_en  (client_en),
  .free_run   (free_run),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .next_core  (next_core),
  .overrun    (overrun)
);

// File: tb/tb_dtd_dispatch.sv
module tb_dtd_dispatch;
  logic       clk = 1'b0;
  logic       rst;
  logic       evt_start, sw_start, client_en, free_run;
  logic [1:0] trig_mode, conv_done, conv_start;
  logic       next_core, overrun;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  dtd_dispatch dut (
    .clk(clk), .rst(rst), .evt_start(evt_start), .sw_start(sw_start),
    .trig_mode(trig_mode), .client_en(client_en), .free_run(free_run),
    .conv_done(conv_done), .conv_start(conv_start),
    .next_core(next_core), .overrun(overrun)
  );

  // Observed word: {start1, start0, next_core, overrun}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {conv_start, next_core, overrun};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive one cycle of stimulus, then sample the registered response
  task automatic cyc(input logic e, input logic s, input logic [1:0] d);
    @(negedge clk);
    evt_start = e; sw_start = s; conv_done = d;
    @(negedge clk);
    evt_start = 0; sw_start = 0; conv_done = 0;
  endtask

  task automatic do_reset(input logic ce, input logic [1:0] md, input logic fr);
    @(negedge clk);
    rst = 1; evt_start = 0; sw_start = 0; conv_done = 0;
    client_en = ce; trig_mode = md; free_run = fr;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1, 2'd1, 0);
    chk("R1 reset state", 4'b0000);
  endtask

  task automatic t_client_off;
    do_reset(0, 2'd1, 0);
    cyc(1, 0, 2'b00); chk("R6 client off, alt code", 4'b0100);
    @(negedge clk);   chk("R2 single cycle pulse", 4'b0000);
    cyc(0, 0, 2'b01);
    trig_mode = 2'd0;
    cyc(0, 1, 2'b00); chk("R6 client off, fan code", 4'b0100);
  endtask

  task automatic t_both;
    do_reset(1, 2'd0, 0);
    cyc(1, 0, 2'b00); chk("R3 fan-out start", 4'b1100);
    cyc(0, 0, 2'b11); chk("R11 completion no restart", 4'b0000);
    cyc(1, 1, 2'b00); chk("R3 fan-out both strobes", 4'b1100);
  endtask

  task automatic t_alt;
    do_reset(1, 2'd1, 0);
    chk("R4 pointer starts at core 0", 4'b0000);
    cyc(1, 0, 2'b00); chk("R4 first to core 0", 4'b0110);
    cyc(0, 0, 2'b01);
    cyc(0, 1, 2'b00); chk("R4 second to core 1", 4'b1000);
    cyc(0, 0, 2'b10);
    cyc(1, 1, 2'b00); chk("R2 merged strobes advance once", 4'b0110);
  endtask

  task automatic t_mode_change;
    do_reset(1, 2'd1, 0);
    cyc(1, 0, 2'b00); chk("R4 pointer advanced", 4'b0110);
    cyc(0, 0, 2'b01);
    trig_mode = 2'd0;
    @(negedge clk);
    trig_mode = 2'd1;
    @(negedge clk); @(negedge clk);
    chk("R5 mode change resets pointer", 4'b0000);
    cyc(1, 0, 2'b00); chk("R5 after change to core 0", 4'b0110);
  endtask

  task automatic t_reserved;
    do_reset(1, 2'd2, 0);
    cyc(1, 0, 2'b00); chk("R7 code 2 ignored", 4'b0000);
    trig_mode = 2'd3; free_run = 1;
    cyc(0, 1, 2'b11); chk("R7 code 3 ignored", 4'b0000);
  endtask

  task automatic t_overrun;
    do_reset(0, 2'd0, 0);
    cyc(1, 0, 2'b00); chk("R8 first start", 4'b0100);
    cyc(1, 0, 2'b00); chk("R8 busy drop sets overrun", 4'b0001);
    cyc(0, 0, 2'b01);
    cyc(0, 1, 2'b00); chk("R8 restart after done, sticky", 4'b0101);
  endtask

  task automatic t_free_both;
    do_reset(1, 2'd0, 1);
    cyc(1, 0, 2'b00); chk("R9 initial fan-out", 4'b1100);
    cyc(0, 0, 2'b01); chk("R9 core 0 self restart", 4'b0100);
    cyc(0, 0, 2'b10); chk("R9 core 1 self restart", 4'b1000);
  endtask

  task automatic t_free_alt;
    do_reset(1, 2'd1, 1);
    cyc(1, 0, 2'b00); chk("R10 kick core 0", 4'b0110);
    cyc(0, 0, 2'b01); chk("R10 done0 starts core 1", 4'b1000);
    cyc(0, 0, 2'b10); chk("R10 done1 starts core 0", 4'b0110);
  endtask

  initial begin
    rst = 1; evt_start = 0; sw_start = 0; conv_done = 0;
    client_en = 0; trig_mode = 0; free_run = 0;
    t_reset();
    t_client_off();
    t_both();
    t_alt();
    t_mode_change();
    t_reserved();
    t_overrun();
    t_free_both();
    t_free_alt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule